// File: doc/BRIEF.md
# Bus Cycle Timing Pulse Generator

This block produces the timing strobes of a byte-wide processor bus. A machine cycle spans eight bus clock periods, and each period is split into a first and a second half by the rising edge in its middle, giving sixteen phases. The block runs from a core clock at twice the bus clock rate, so it advances one phase per core clock edge and all of its logic uses a single clock edge.

From the phase count it forms two positive timing pulses and an active-low memory-read strobe. A cycle-type input picks, once per machine cycle, between a memory-read cycle (such as an instruction fetch) and the execute cycle of an output instruction. In a read cycle the strobe is held low throughout. In an output-execute cycle it stays high for the first three phases. The phase number and a cycle-start marker are exported so neighbouring logic can align to the cycle.

Top module: `bus_cycle_timer`

## Requirements
- R1: `phase` holds the value 2*period + half (period 0..7, half 0 = first, 1 = second). It rises by one on each clock edge and wraps from 15 to 0.
- R2: `tp_early` is high exactly while `phase` is 2 or 3, which is the whole of period 1.
- R3: `tp_late` is high exactly while `phase` is 13 or 14, which is the second half of period 6 and the first half of period 7.
- R4: In a cycle whose type is read (`cyc_sel` = 0), `rd_n` is low in all sixteen phases.
- R5: In a cycle whose type is output-execute (`cyc_sel` = 1), `rd_n` is high in phases 0, 1 and 2 and low in phases 3 to 15.
- R6: `cyc_sel` is sampled only on the edge that enters phase 0. A change at any other time has no effect on `rd_n` until the next cycle begins.
- R7: `cyc_start` is high in phase 0 and low in every other phase.
- R8: While `rst` is high at a clock edge, the outputs become phase 0, both pulses low, `rd_n` high and `cyc_start` high. The cycle that follows reset runs as an output-execute cycle whatever `cyc_sel` holds.
- R9: Every output is registered and changes on the same edge as `phase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the bus clock rate |
| rst | input | 1 | Synchronous reset, active high |
| cyc_sel | input | 1 | Cycle type for the next cycle: 0 read, 1 output-execute |
| tp_early | output | 1 | First timing pulse, period 1 |
| tp_late | output | 1 | Second timing pulse, phases 13 and 14 |
| rd_n | output | 1 | Memory-read strobe, active low |
| phase | output | 4 | Current phase number |
| cyc_start | output | 1 | High during phase 0 |

## Verification
Every output comes from a register loaded from the next-phase value, so a result for phase p is visible in the same clock period in which `phase` reads p. No output lags the phase count. `cyc_sel` takes effect only one edge later, on the edge that wraps the count to 0, and it governs the whole of the cycle that follows. The bench drives inputs and samples outputs at falling edges. It sets the cycle type while `phase` reads 15, then compares each of the next sixteen samples with the values expected for that phase. A mid-cycle toggle of `cyc_sel` is checked against the unchanged strobe pattern of the current cycle.

// File: rtl/bus_timing_pkg.sv
package bus_timing_pkg;

   typedef enum logic {
      CYC_READ    = 1'b0,
      CYC_OUTEXEC = 1'b1
   } cyc_kind_e;

   // phase index of (period, half)
   function automatic int phase_of(input int per, input int half, input int phases);
      return (2 * per + half) % phases;
   endfunction

endpackage

// File: rtl/btp_phase_ctr.sv
module btp_phase_ctr #(
   parameter int PHASES = 16,
   localparam int PW = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] ph,
   output logic [PW-1:0] ph_nxt,
   output logic          wrap_nxt
);
   localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

   if (PHASES < 4 || (PHASES & (PHASES - 1)) != 0) begin : g_bad_phases
      $error("btp_phase_ctr: PHASES must be a power of two >= 4");
   end

   always_comb begin
      if (rst || ph == LAST_PH) ph_nxt = '0;
      else                      ph_nxt = ph + 1'b1;
   end

   assign wrap_nxt = (ph_nxt == '0);

   always_ff @(posedge clk) begin
      ph <= ph_nxt;
   end

   a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
      (ph != LAST_PH) |=> (ph == $past(ph) + 1'b1));
   a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
      (ph == LAST_PH) |=> (ph == '0));

endmodule

// File: rtl/btp_window.sv
module btp_window #(
   parameter int PHASES = 16,
   parameter int FIRST  = 2,
   parameter int LEN    = 2,
   localparam int PW    = $clog2(PHASES),
   localparam int LAST  = (FIRST + LEN - 1) % PHASES
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] ph_nxt,
   output logic          q
);
   localparam logic [PW-1:0] F_PH = PW'(FIRST);
   localparam logic [PW-1:0] L_PH = PW'(LAST);

   logic hit;

   if (FIRST < 1 || FIRST >= PHASES) begin : g_bad_first
      $error("btp_window: FIRST out of range");
   end
   if (LEN < 1 || LEN >= PHASES) begin : g_bad_len
      $error("btp_window: LEN out of range");
   end

   if (FIRST <= LAST) begin : g_flat
      assign hit = (ph_nxt >= F_PH) && (ph_nxt <= L_PH);
   end else begin : g_wrap
      assign hit = (ph_nxt >= F_PH) || (ph_nxt <= L_PH);
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= hit;
   end

   a_r9_len: assert property (@(posedge clk) disable iff (rst)
      $rose(q) |=> q);

endmodule

// File: rtl/btp_rdstrobe.sv
module btp_rdstrobe
   import bus_timing_pkg::*;
#(
   parameter int PHASES   = 16,
   parameter int LOW_FROM = 3,
   localparam int PW      = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] ph,
   input  logic [PW-1:0] ph_nxt,
   input  logic          wrap_nxt,
   input  logic          cyc_sel,
   output logic          rd_n
);
   localparam logic [PW-1:0] LOW_PH = PW'(LOW_FROM);

   cyc_kind_e kind_q, kind_nxt;

   if (LOW_FROM < 1 || LOW_FROM >= PHASES) begin : g_bad_low
      $error("btp_rdstrobe: LOW_FROM out of range");
   end

   always_comb begin
      if (rst)           kind_nxt = CYC_OUTEXEC;
      else if (wrap_nxt) kind_nxt = cyc_kind_e'(cyc_sel);
      else               kind_nxt = kind_q;
   end

   always_ff @(posedge clk) begin
      kind_q <= kind_nxt;
      if (rst)                       rd_n <= 1'b1;
      else if (kind_nxt == CYC_READ) rd_n <= 1'b0;
      else                           rd_n <= (ph_nxt < LOW_PH);
   end

   a_r4_read_low: assert property (@(posedge clk) disable iff (rst)
      (kind_q == CYC_READ) |-> !rd_n);
   a_r5_exec_high_early: assert property (@(posedge clk) disable iff (rst)
      (kind_q == CYC_OUTEXEC && ph < LOW_PH) |-> rd_n);
   a_r5_exec_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(rd_n) |-> (ph == LOW_PH || ph == '0));
   a_r6_kind_hold: assert property (@(posedge clk) disable iff (rst)
      (ph != '0) |-> $stable(kind_q));

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
   import bus_timing_pkg::*;
#(
   parameter int PERIODS       = 8,
   parameter int EARLY_PER     = 1,
   parameter int EARLY_HALF    = 0,
   parameter int EARLY_LEN     = 2,
   parameter int LATE_PER      = 6,
   parameter int LATE_HALF     = 1,
   parameter int LATE_LEN      = 2,
   parameter int RD_LOW_PER    = 1,
   parameter int RD_LOW_HALF   = 1,
   localparam int PHASES       = 2 * PERIODS,
   localparam int PW           = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cyc_sel,
   output logic          tp_early,
   output logic          tp_late,
   output logic          rd_n,
   output logic [PW-1:0] phase,
   output logic          cyc_start
);
   localparam int EARLY_FIRST = phase_of(EARLY_PER, EARLY_HALF, PHASES);
   localparam int LATE_FIRST  = phase_of(LATE_PER, LATE_HALF, PHASES);
   localparam int RD_LOW_PH   = phase_of(RD_LOW_PER, RD_LOW_HALF, PHASES);
   localparam logic [PW-1:0] E0 = PW'(EARLY_FIRST);
   localparam logic [PW-1:0] L0 = PW'(LATE_FIRST);

   logic [PW-1:0] ph_nxt;
   logic          wrap_nxt;

   if (PERIODS < 2) begin : g_bad_periods
      $error("bus_cycle_timer: PERIODS must be at least 2");
   end
   if (EARLY_HALF > 1 || LATE_HALF > 1 || RD_LOW_HALF > 1) begin : g_bad_half
      $error("bus_cycle_timer: half index must be 0 or 1");
   end

   btp_phase_ctr #(.PHASES(PHASES)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .ph       (phase),
      .ph_nxt   (ph_nxt),
      .wrap_nxt (wrap_nxt)
   );

   btp_window #(.PHASES(PHASES), .FIRST(EARLY_FIRST), .LEN(EARLY_LEN)) u_early (
      .clk    (clk),
      .rst    (rst),
      .ph_nxt (ph_nxt),
      .q      (tp_early)
   );

   btp_window #(.PHASES(PHASES), .FIRST(LATE_FIRST), .LEN(LATE_LEN)) u_late (
      .clk    (clk),
      .rst    (rst),
      .ph_nxt (ph_nxt),
      .q      (tp_late)
   );

   btp_rdstrobe #(.PHASES(PHASES), .LOW_FROM(RD_LOW_PH)) u_rd (
      .clk      (clk),
      .rst      (rst),
      .ph       (phase),
      .ph_nxt   (ph_nxt),
      .wrap_nxt (wrap_nxt),
      .cyc_sel  (cyc_sel),
      .rd_n     (rd_n)
   );

   always_ff @(posedge clk) begin
      if (rst) cyc_start <= 1'b1;
      else     cyc_start <= wrap_nxt;
   end

   a_r7_start_phase: assert property (@(posedge clk) disable iff (rst)
      cyc_start |-> (phase == '0));
   a_r2_early_start: assert property (@(posedge clk) disable iff (rst)
      $rose(tp_early) |-> (phase == E0));
   a_r3_late_start: assert property (@(posedge clk) disable iff (rst)
      $rose(tp_late) |-> (phase == L0));
   a_r3_pulses_apart: assert property (@(posedge clk) disable iff (rst)
      !(tp_early && tp_late));
   a_r8_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (phase == '0 && !tp_early && !tp_late && rd_n && cyc_start));

endmodule

// File: tb/bus_cycle_timer_test.sv
module bus_cycle_timer_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cyc_sel = 1'b0;
   logic       tp_early, tp_late, rd_n, cyc_start;
   logic [3:0] phase;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bus_cycle_timer uut (
      .clk       (clk),
      .rst       (rst),
      .cyc_sel   (cyc_sel),
      .tp_early  (tp_early),
      .tp_late   (tp_late),
      .rd_n      (rd_n),
      .phase     (phase),
      .cyc_start (cyc_start)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // check every output against phase i of a cycle of kind m (1 = output-execute)
   task automatic chk_phase(input int i, input bit m, input string req);
      chk("R1", "phase", int'(phase), i);
      chk("R2", "tp_early", int'(tp_early), int'(i == 2 || i == 3));
      chk("R3", "tp_late", int'(tp_late), int'(i == 13 || i == 14));
      chk(req, "rd_n", int'(rd_n), m ? int'(i <= 2) : 0);
      chk("R7", "cyc_start", int'(cyc_start), int'(i == 0));
   endtask

   task automatic to_last_phase();
      while (phase != 4'd15) @(negedge clk);
   endtask

   // R4 R5 R9: one full cycle of the given kind
   task automatic run_cycle(input bit m, input bit toggle_mid);
      to_last_phase();
      cyc_sel = m;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         chk_phase(i, m, m ? "R5" : "R4");
         if (toggle_mid && (i == 1 || i == 7)) cyc_sel = ~m; // R6: ignored mid-cycle
         if (toggle_mid && i == 12) cyc_sel = m;
      end
   endtask

   // R8: reset state, then first cycle runs as output-execute despite cyc_sel = 0
   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      cyc_sel = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R8", "reset phase", int'(phase), 0);
      chk("R8", "reset tp_early", int'(tp_early), 0);
      chk("R8", "reset tp_late", int'(tp_late), 0);
      chk("R8", "reset rd_n", int'(rd_n), 1);
      chk("R8", "reset cyc_start", int'(cyc_start), 1);
      rst = 1'b0;
      for (int i = 1; i < 16; i++) begin
         @(negedge clk);
         chk_phase(i, 1'b1, "R8");
      end
   endtask

   task automatic t_read_cycles();
      run_cycle(1'b0, 1'b0);
      run_cycle(1'b0, 1'b0);
   endtask

   task automatic t_exec_cycles();
      run_cycle(1'b1, 1'b0);
      run_cycle(1'b1, 1'b0);
   endtask

   task automatic t_alternate();
      run_cycle(1'b0, 1'b0);
      run_cycle(1'b1, 1'b0);
      run_cycle(1'b0, 1'b0);
   endtask

   // R6: toggling mid-cycle has no effect on this cycle
   task automatic t_mid_change();
      run_cycle(1'b1, 1'b1);
      run_cycle(1'b0, 1'b1);
   endtask

   // R8: reset in the middle of a cycle
   task automatic t_reset_mid();
      run_cycle(1'b0, 1'b0);
      repeat (6) @(negedge clk);
      t_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_read_cycles();
      t_exec_cycles();
      t_alternate();
      t_mid_change();
      t_reset_mid();
      run_cycle(1'b0, 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule